// File: doc/BRIEF.md
# Subcarrier Costas Arm and Symbol Integrator Bank

This block sits behind a carrier demodulator that delivers in-phase and quadrature carrier samples. A square-wave subcarrier phase drives two references, a sine-phase one and a cosine-phase one that leads it by a quarter cycle. Each reference is a signed amplitude, so the software gain is applied without a separate multiplier. The amplitude comes from a 16-level scale code and a rate flag that multiplies it by four for fast symbol rates. Each arm product is integrated over one symbol. A symbol ends on the sample that carries the boundary strobe. The three per-symbol sums are the soft symbol (Q times sine), the quadrature Costas arm (Q times cosine) and the sideband-aiding arm (I times sine).

Each completed symbol also feeds three statistics that are accumulated over a subcarrier update period. They are the Costas phase error (soft symbol times quadrature arm), the power sum (soft symbol squared) and the split-symbol product (first-half sum times second-half sum of the soft-symbol channel). A period closes on the symbol whose final sample carries the period-end strobe. The loop filter and the SNR arithmetic that use these sums run elsewhere.

Top module: `sc_costas_bank`

## Requirements
- R1: While reset is low, and on the first cycle after it, every output is zero and both valid pulses are low.
- R2: The sine reference is +amplitude when phase bit 15 is 0 and -amplitude when it is 1. The soft symbol is the sum over the symbol of car_q times the sine reference.
- R3: The cosine reference is +amplitude when phase bits 15 and 14 are equal (00 or 11) and -amplitude otherwise. The quadrature arm is the sum of car_q times the cosine reference.
- R4: The aiding arm is the sum over the symbol of car_i times the sine reference.
- R5: The reference amplitude is (scale_lvl + 1) when fast_rate is 0, and 4 × (scale_lvl + 1) when fast_rate is 1.
- R6: The edge that takes a valid sample with sym_strobe high latches the three sums. sym_valid is then high for exactly the next cycle, and the following symbol starts from zero.
- R7: A cycle with smp_valid low changes no sum, counter or output, whatever car_i, car_q, sym_strobe and per_end carry.
- R8: phase_err is the sum of soft symbol × quadrature arm over every symbol of the period, including the closing symbol. It is latched, with a one-cycle per_valid, on the same edge as that symbol's sums.
- R9: pwr_stat is the sum of soft symbol squared over the period.
- R10: split_stat is the sum, over the period, of H1 × H2. H1 is the soft-symbol channel summed over sample indices below sym_len/2, and H2 is the same channel summed over the rest of the symbol. sym_len must be even.
- R11: After a period closes, the next period's statistics start from zero.
- R12: A per_end on a valid sample without sym_strobe has no effect: no per_valid, and the running period sums continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample qualifier |
| car_i | input | 8 | Carrier in-phase sample, signed |
| car_q | input | 8 | Carrier quadrature sample, signed |
| sc_phase | input | 16 | Subcarrier phase accumulator value |
| scale_lvl | input | 4 | Quantised scale code |
| fast_rate | input | 1 | High symbol rate flag (amplitude × 4) |
| sym_len | input | 8 | Samples per symbol, even |
| sym_strobe | input | 1 | Marks the last sample of a symbol |
| per_end | input | 1 | Closes the update period at this symbol end |
| sym_valid | output | 1 | Per-symbol sums are new |
| soft_sym | output | 24 | Soft symbol sum, signed |
| quad_arm | output | 24 | Quadrature Costas arm sum, signed |
| aid_arm | output | 24 | Sideband-aiding arm sum, signed |
| per_valid | output | 1 | Period statistics are new |
| phase_err | output | 56 | Costas phase error, signed |
| pwr_stat | output | 56 | Power statistic, signed |
| split_stat | output | 56 | Split-symbol statistic, signed |

## Verification
The assertions assume three things about the inputs. sym_len is even. It is held steady through each symbol. A valid sample with sym_strobe high arrives exactly at index sym_len-1 of that symbol. The stimulus builds every symbol from its length, so the strobe always lands on the final sample. Lengths run from 2 to 32, all even. Idle cycles with smp_valid low carry deliberately hostile strobes and data, which the assumptions permit because they only constrain qualified samples.

// File: rtl/sc_costas_pkg.sv
`timescale 1ns/1ps
package sc_costas_pkg;

  typedef struct packed {
    logic sin_neg;
    logic cos_neg;
  } ref_sign_t;

  // Square-wave signs from the two top phase bits; cosine leads by 90 degrees.
  function automatic ref_sign_t phase_to_sign(input logic [1:0] top);
    ref_sign_t r;
    r.sin_neg = top[1];
    r.cos_neg = top[1] ^ top[0];
    return r;
  endfunction

endpackage

// File: rtl/sc_refgen.sv
`timescale 1ns/1ps
module sc_refgen
  import sc_costas_pkg::*;
#(
  parameter int PHASE_W    = 16,
  parameter int LVL_W      = 4,
  parameter int FAST_SHIFT = 2,
  localparam int AMP_W     = LVL_W + 1 + FAST_SHIFT
) (
  input  logic [PHASE_W-1:0] phase,
  input  logic [LVL_W-1:0]   scale_lvl,
  input  logic               fast_rate,
  output ref_sign_t          sgn,
  output logic [AMP_W-1:0]   amp
);

  logic [AMP_W-1:0] base_amp;

  assign sgn      = phase_to_sign(phase[PHASE_W-1 -: 2]);
  assign base_amp = AMP_W'(scale_lvl) + AMP_W'(1);
  assign amp      = fast_rate ? (base_amp << FAST_SHIFT) : base_amp;

endmodule

// File: rtl/sc_sym_integ.sv
`timescale 1ns/1ps
module sc_sym_integ
  import sc_costas_pkg::*;
#(
  parameter int SW    = 8,
  parameter int AMP_W = 7,
  parameter int CNT_W = 8,
  localparam int PROD_W = SW + AMP_W + 1,
  localparam int SYM_W  = PROD_W + CNT_W,
  localparam int N_ARM  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  input  logic signed [SW-1:0]    car_i,
  input  logic signed [SW-1:0]    car_q,
  input  ref_sign_t               sgn,
  input  logic [AMP_W-1:0]        amp,
  input  logic [CNT_W-1:0]        sym_len,
  input  logic                    sym_strobe,
  output logic                    sym_valid,
  output logic signed [SYM_W-1:0] sym_out [N_ARM],
  output logic                    sym_done,
  output logic signed [SYM_W-1:0] fin_arm [N_ARM],
  output logic signed [SYM_W-1:0] fin_h1,
  output logic signed [SYM_W-1:0] fin_h2
);

  // Reference product: sample times signed square-wave amplitude.
  function automatic logic signed [PROD_W-1:0] ref_mul(
    input logic signed [SW-1:0] s, input logic neg, input logic [AMP_W-1:0] a);
    logic signed [PROD_W-1:0] m;
    m = PROD_W'(s) * PROD_W'($signed({1'b0, a}));
    return neg ? -m : m;
  endfunction

  logic signed [SW-1:0]     arm_smp  [N_ARM];
  logic                     arm_neg  [N_ARM];
  logic signed [PROD_W-1:0] arm_prod [N_ARM];
  logic [CNT_W-1:0]         idx;
  logic signed [SYM_W-1:0]  h1_acc, h2_acc;
  logic                     first_half;

  assign arm_smp[0] = car_q;  assign arm_neg[0] = sgn.sin_neg;  // soft symbol
  assign arm_smp[1] = car_q;  assign arm_neg[1] = sgn.cos_neg;  // quadrature arm
  assign arm_smp[2] = car_i;  assign arm_neg[2] = sgn.sin_neg;  // aiding arm

  assign sym_done   = smp_valid & sym_strobe;
  assign first_half = idx < (sym_len >> 1);

  for (genvar a = 0; a < N_ARM; a++) begin : g_arm
    logic signed [SYM_W-1:0] acc, held;
    assign arm_prod[a] = ref_mul(arm_smp[a], arm_neg[a], amp);
    assign fin_arm[a]  = acc + SYM_W'(arm_prod[a]);
    assign sym_out[a]  = held;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc  <= '0;
        held <= '0;
      end else if (smp_valid) begin
        if (sym_strobe) begin
          held <= fin_arm[a];
          acc  <= '0;
        end else begin
          acc  <= fin_arm[a];
        end
      end
    end
  end

  assign fin_h1 = first_half ? h1_acc + SYM_W'(arm_prod[0]) : h1_acc;
  assign fin_h2 = first_half ? h2_acc : h2_acc + SYM_W'(arm_prod[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx       <= '0;
      h1_acc    <= '0;
      h2_acc    <= '0;
      sym_valid <= 1'b0;
    end else begin
      sym_valid <= sym_done;
      if (smp_valid) begin
        if (sym_strobe) begin
          idx    <= '0;
          h1_acc <= '0;
          h2_acc <= '0;
        end else begin
          idx    <= idx + CNT_W'(1);
          h1_acc <= fin_h1;
          h2_acc <= fin_h2;
        end
      end
    end
  end

  // R10: the split point needs an even symbol length (input assumption)
  a_r10_even_len: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> !sym_len[0]);
  // R6: a boundary strobe only ever arrives on the final sample index
  a_r6_strobe_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    sym_done |-> idx == sym_len - CNT_W'(1));
  // R6: per-symbol valid is a single-cycle pulse
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> !sym_valid);
  // R6: the sample counter restarts with every latched symbol
  a_r6_idx_restart: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> idx == '0);

endmodule

// File: rtl/sc_period_stats.sv
`timescale 1ns/1ps
module sc_period_stats #(
  parameter int SYM_W  = 24,
  parameter int GROW_W = 8,
  localparam int PP_W   = 2 * SYM_W,
  localparam int STAT_W = PP_W + GROW_W,
  localparam int N_STAT = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sym_done,
  input  logic                     per_end,
  input  logic signed [SYM_W-1:0]  fin_sin,
  input  logic signed [SYM_W-1:0]  fin_cos,
  input  logic signed [SYM_W-1:0]  fin_h1,
  input  logic signed [SYM_W-1:0]  fin_h2,
  output logic                     per_valid,
  output logic signed [STAT_W-1:0] stat_out [N_STAT]
);

  function automatic logic signed [PP_W-1:0] pair_mul(
    input logic signed [SYM_W-1:0] x, input logic signed [SYM_W-1:0] y);
    return PP_W'(x) * PP_W'(y);
  endfunction

  logic signed [SYM_W-1:0] op_a [N_STAT];
  logic signed [SYM_W-1:0] op_b [N_STAT];

  assign op_a[0] = fin_sin;  assign op_b[0] = fin_cos;   // Costas phase error
  assign op_a[1] = fin_sin;  assign op_b[1] = fin_sin;   // power
  assign op_a[2] = fin_h1;   assign op_b[2] = fin_h2;    // split-symbol

  for (genvar s = 0; s < N_STAT; s++) begin : g_stat
    logic signed [STAT_W-1:0] acc, held, nxt;
    assign nxt         = acc + STAT_W'(pair_mul(op_a[s], op_b[s]));
    assign stat_out[s] = held;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc  <= '0;
        held <= '0;
      end else if (sym_done) begin
        if (per_end) begin
          held <= nxt;
          acc  <= '0;
        end else begin
          acc  <= nxt;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) per_valid <= 1'b0;
    else        per_valid <= sym_done & per_end;
  end

  // R9: a sum of squares never comes out negative
  a_r9_power_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
    per_valid |-> !stat_out[1][STAT_W-1]);

endmodule

// File: rtl/sc_costas_bank.sv
`timescale 1ns/1ps
module sc_costas_bank
  import sc_costas_pkg::*;
#(
  parameter int SW         = 8,
  parameter int PHASE_W    = 16,
  parameter int LVL_W      = 4,
  parameter int FAST_SHIFT = 2,
  parameter int CNT_W      = 8,
  parameter int GROW_W     = 8,
  localparam int AMP_W  = LVL_W + 1 + FAST_SHIFT,
  localparam int SYM_W  = SW + AMP_W + 1 + CNT_W,
  localparam int STAT_W = 2 * SYM_W + GROW_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic signed [SW-1:0]     car_i,
  input  logic signed [SW-1:0]     car_q,
  input  logic [PHASE_W-1:0]       sc_phase,
  input  logic [LVL_W-1:0]         scale_lvl,
  input  logic                     fast_rate,
  input  logic [CNT_W-1:0]         sym_len,
  input  logic                     sym_strobe,
  input  logic                     per_end,
  output logic                     sym_valid,
  output logic signed [SYM_W-1:0]  soft_sym,
  output logic signed [SYM_W-1:0]  quad_arm,
  output logic signed [SYM_W-1:0]  aid_arm,
  output logic                     per_valid,
  output logic signed [STAT_W-1:0] phase_err,
  output logic signed [STAT_W-1:0] pwr_stat,
  output logic signed [STAT_W-1:0] split_stat
);

  ref_sign_t               ref_sgn;
  logic [AMP_W-1:0]        ref_amp;
  logic                    sym_done;
  logic signed [SYM_W-1:0] sym_out [3];
  logic signed [SYM_W-1:0] fin_arm [3];
  logic signed [SYM_W-1:0] fin_h1, fin_h2;
  logic signed [STAT_W-1:0] stat_out [3];

  sc_refgen #(.PHASE_W(PHASE_W), .LVL_W(LVL_W), .FAST_SHIFT(FAST_SHIFT)) u_ref (
    .phase(sc_phase), .scale_lvl(scale_lvl), .fast_rate(fast_rate),
    .sgn(ref_sgn), .amp(ref_amp));

  sc_sym_integ #(.SW(SW), .AMP_W(AMP_W), .CNT_W(CNT_W)) u_integ (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .car_i(car_i), .car_q(car_q),
    .sgn(ref_sgn), .amp(ref_amp), .sym_len(sym_len), .sym_strobe(sym_strobe),
    .sym_valid(sym_valid), .sym_out(sym_out), .sym_done(sym_done),
    .fin_arm(fin_arm), .fin_h1(fin_h1), .fin_h2(fin_h2));

  sc_period_stats #(.SYM_W(SYM_W), .GROW_W(GROW_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .sym_done(sym_done), .per_end(per_end),
    .fin_sin(fin_arm[0]), .fin_cos(fin_arm[1]), .fin_h1(fin_h1), .fin_h2(fin_h2),
    .per_valid(per_valid), .stat_out(stat_out));

  assign soft_sym   = sym_out[0];
  assign quad_arm   = sym_out[1];
  assign aid_arm    = sym_out[2];
  assign phase_err  = stat_out[0];
  assign pwr_stat   = stat_out[1];
  assign split_stat = stat_out[2];

  // R8: a period closes only together with a symbol latch
  a_r8_period_with_symbol: assert property (@(posedge clk) disable iff (!rst_n)
    per_valid |-> sym_valid);
  // R12: per_end without a symbol end never yields period results
  a_r12_stray_end_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && per_end && !sym_strobe) |=> !per_valid);

endmodule

// File: tb/sc_costas_bank_test.sv
`timescale 1ns/1ps
module sc_costas_bank_test;

  logic clk = 1'b0;
  logic rst_n;
  logic smp_valid, fast_rate, sym_strobe, per_end;
  logic signed [7:0] car_i, car_q;
  logic [15:0] sc_phase;
  logic [3:0]  scale_lvl;
  logic [7:0]  sym_len;
  logic sym_valid, per_valid;
  logic signed [23:0] soft_sym, quad_arm, aid_arm;
  logic signed [55:0] phase_err, pwr_stat, split_stat;

  int checks = 0;
  int errors = 0;
  bit pending_stray = 1'b0;
  longint acc_pe = 0, acc_pw = 0, acc_sp = 0;

  always #2.5 clk = ~clk;

  sc_costas_bank uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .car_i(car_i), .car_q(car_q),
    .sc_phase(sc_phase), .scale_lvl(scale_lvl), .fast_rate(fast_rate),
    .sym_len(sym_len), .sym_strobe(sym_strobe), .per_end(per_end),
    .sym_valid(sym_valid), .soft_sym(soft_sym), .quad_arm(quad_arm), .aid_arm(aid_arm),
    .per_valid(per_valid), .phase_err(phase_err), .pwr_stat(pwr_stat),
    .split_stat(split_stat));

  // Rows: len, scale, fast, q0, dq, i0, phase0, step, gap, period end, stray end
  localparam int NROW = 8;
  localparam int T_LEN  [NROW] = '{8, 8, 16, 4, 2, 32, 6, 10};
  localparam int T_SC   [NROW] = '{0, 3, 15, 7, 1, 9, 5, 12};
  localparam int T_FA   [NROW] = '{0, 0, 1, 1, 0, 1, 0, 1};
  localparam int T_Q0   [NROW] = '{20, -30, 50, -60, 5, 60, -10, 33};
  localparam int T_DQ   [NROW] = '{1, 2, -2, 1, 0, -2, 3, -1};
  localparam int T_I0   [NROW] = '{-5, 7, 10, -40, 3, -60, 25, -1};
  localparam int T_PH   [NROW] = '{'h0000, 'h4000, 'hC000, 'h8000, 'h1000, 'h0000, 'hE000, 'h3000};
  localparam int T_ST   [NROW] = '{'h2000, 'h1000, 'h0800, 'h4000, 'h8000, 'h0400, 'h2A00, 'h1900};
  localparam int T_GAP  [NROW] = '{0, 1, 0, 0, 1, 0, 1, 0};
  localparam int T_PEND [NROW] = '{0, 0, 1, 0, 0, 1, 0, 1};
  localparam int T_STRY [NROW] = '{0, 1, 0, 0, 0, 0, 1, 0};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (pending_stray) begin
      chk(per_valid == 1'b0, "R12 stray period end", longint'(per_valid), 0);
      pending_stray = 1'b0;
    end
  endtask

  task automatic idle_drive();
    smp_valid = 1'b0; car_q = 8'sd99; car_i = -8'sd99;
    sym_strobe = 1'b1; per_end = 1'b1;   // R7: hostile values while unqualified
  endtask

  task automatic run_sym(input int len, sc, fa, q0, dq, i0, ph0, st, gap, pend, stray);
    longint es = 0, ec = 0, ea = 0, h1 = 0, h2 = 0;
    int amp = (sc + 1) * (fa != 0 ? 4 : 1);          // R5
    sym_len = 8'(len);
    for (int k = 0; k < len; k++) begin
      logic [15:0] ph = 16'(ph0 + k * st);
      int q = q0 + k * dq;
      int i = i0 - k * dq;
      int ss = ph[15] ? -1 : 1;                     // R2
      int cs = (ph[15] == ph[14]) ? 1 : -1;         // R3
      es += longint'(q * ss * amp);
      ec += longint'(q * cs * amp);
      ea += longint'(i * ss * amp);                 // R4
      if (k < len / 2) h1 += longint'(q * ss * amp);
      else             h2 += longint'(q * ss * amp);
      tick();
      smp_valid = 1'b1; car_q = 8'(q); car_i = 8'(i); sc_phase = ph;
      scale_lvl = 4'(sc); fast_rate = (fa != 0);
      sym_strobe = (k == len - 1);
      per_end = ((pend != 0) && k == len - 1) || ((stray != 0) && k == 1);
      if ((stray != 0) && k == 1) pending_stray = 1'b1;
      if ((gap != 0) && k != len - 1) begin
        tick();
        idle_drive();
      end
    end
    tick();
    idle_drive();
    chk(sym_valid == 1'b1, "R6 sym_valid", longint'(sym_valid), 1);
    chk(longint'(soft_sym) == es, "R2 soft symbol", longint'(soft_sym), es);
    chk(longint'(quad_arm) == ec, "R3 quadrature arm", longint'(quad_arm), ec);
    chk(longint'(aid_arm) == ea, "R4 aiding arm", longint'(aid_arm), ea);
    acc_pe += es * ec;
    acc_pw += es * es;
    acc_sp += h1 * h2;
    if (pend != 0) begin
      chk(per_valid == 1'b1, "R8 per_valid", longint'(per_valid), 1);
      chk(longint'(phase_err) == acc_pe, "R8 phase error", longint'(phase_err), acc_pe);
      chk(longint'(pwr_stat) == acc_pw, "R9 power", longint'(pwr_stat), acc_pw);
      chk(longint'(split_stat) == acc_sp, "R10 split", longint'(split_stat), acc_sp);
      acc_pe = 0; acc_pw = 0; acc_sp = 0;        // R11: next period from zero
    end else begin
      chk(per_valid == 1'b0, "R8 no period mid-run", longint'(per_valid), 0);
    end
    tick();
    chk(sym_valid == 1'b0, "R6 single pulse", longint'(sym_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; car_i = '0; car_q = '0; sc_phase = '0;
    scale_lvl = '0; fast_rate = 1'b0; sym_len = 8'd8; sym_strobe = 1'b0; per_end = 1'b0;
    repeat (3) @(negedge clk);
    chk(sym_valid == 0 && per_valid == 0, "R1 valids in reset", longint'(sym_valid), 0);
    chk(soft_sym == 0 && quad_arm == 0 && aid_arm == 0, "R1 sums in reset", longint'(soft_sym), 0);
    chk(phase_err == 0 && pwr_stat == 0 && split_stat == 0, "R1 stats in reset",
        longint'(phase_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sym_valid == 0 && per_valid == 0 && soft_sym == 0, "R1 first cycle",
        longint'(soft_sym), 0);

    // Vector table: R2-R12 across lengths, scales, rates, phases and gaps
    for (int r = 0; r < NROW; r++)
      run_sym(T_LEN[r], T_SC[r], T_FA[r], T_Q0[r], T_DQ[r], T_I0[r],
              T_PH[r], T_ST[r], T_GAP[r], T_PEND[r], T_STRY[r]);

    // R7: idle cycles leave the latched outputs untouched
    repeat (4) tick();
    chk(sym_valid == 0 && per_valid == 0, "R7 no pulses while idle", longint'(sym_valid), 0);

    // R1: reset mid-period clears everything; R11: new period holds only new symbol
    run_sym(8, 2, 1, 40, -3, 12, 'h0000, 'h2000, 0, 0, 0);
    rst_n = 1'b0;
    tick();
    chk(soft_sym == 0 && phase_err == 0, "R1 reset clears outputs", longint'(soft_sym), 0);
    rst_n = 1'b1;
    acc_pe = 0; acc_pw = 0; acc_sp = 0;
    run_sym(4, 15, 1, -128 + 3, 0, 127, 'h6000, 'h4000, 0, 1, 0);
    run_sym(2, 0, 0, 1, 1, -1, 'hF000, 'h1000, 1, 1, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule